// File: doc/BRIEF.md
# Shared-Vector External Interrupt Unit

This block handles two external interrupt pins for a small CPU. Both pins share one interrupt vector. The unit raises a single combined request line, and the CPU's global interrupt mask blocks that line. Each pin passes through a two-flop synchronizer. Edges are found by comparing the current synchronized sample with the one from the previous cycle.

Pin 0 is active low, and a falling edge on it is latched as a pending request. One option bit in its own register sets the pin-0 trigger. When the bit is 0, the trigger is the edge plus a held low level. When it is 1, the trigger is the edge only. Only the first write to this register after reset takes effect. The CPU's vector-fetch acknowledge clears a latched pin-0 request.

Pin 1 has its own control/status register with these parts:
- an enable bit;
- a polarity bit;
- a level-add bit;
- a sticky flag that tells the service routine which source fired;
- a write-one clear strobe;
- a readback of the synchronized pin level.

The unit has three two-state machines:
- **Option lock:** `OPT_OPEN` moves to `OPT_LOCKED` on any write to the option register. `OPT_LOCKED` holds until reset.
- **Pin-0 latch:** `P0_IDLE` moves to `P0_PENDING` on a synchronized falling edge. `P0_PENDING` returns to `P0_IDLE` on `irq_ack` when no new edge arrives in the same cycle.
- **Pin-1 flag:** `F1_CLEAR` moves to `F1_SET` on a valid enabled trigger. `F1_SET` returns to `F1_CLEAR` on a clear strobe when no trigger arrives in the same cycle.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, both registers read back as follows, and `irq_req` is 0.
  - The pin-1 control register reads 0x00 while pin 1 is low.
  - The option register reads 0x00.
- R2: While `cpu_imask` is 1, `irq_req` is 0. When `cpu_imask` is 0, `irq_req` follows the pending sources.
- R3: A falling edge on `pin0_n` is latched (`P0_PENDING`). The request stays after the pin returns high, and `irq_req` rises within four clock cycles of the edge.
- R4: Option bit 1 selects the pin-0 trigger.
  - When it is 0, a held low level on `pin0_n` requests even with no latched edge.
  - When it is 1, only the latched edge requests.
- R5: The first write to the option register after reset sets bit 1. Every later write is ignored until the next reset.
- R6: In the pin-1 register, bit 4 is the enable. When it is 0, no pin-1 activity sets the flag or raises `irq_req`.
- R7: Two bits of the pin-1 register select the trigger:
  - Bit 2 is polarity: 0 means falling edge or low level, and 1 means rising edge or high level.
  - Bit 3 adds sensitivity to the active level.
  - The selected trigger sets the flag in bit 5.
  - An edge of the other polarity does not set the flag.
- R8: In a level mode, the flag sets again after a clear while the pin stays at its active level.
- R9: Writing 1 to bit 1 of the pin-1 register clears the flag. Bit 1 always reads 0.
- R10: Bit 0 of the pin-1 register returns the synchronized level of `pin1`.
- R11: If a trigger and a clear (pin-1 strobe or pin-0 acknowledge) arrive in the same cycle, the source stays set.
- R12: `irq_ack` clears a latched pin-0 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cpu_imask | input | 1 | CPU global interrupt mask; 1 blocks requests |
| irq_ack | input | 1 | Vector-fetch acknowledge; clears the pin-0 latch |
| pin0_n | input | 1 | External interrupt pin 0, active low, asynchronous |
| pin1 | input | 1 | External interrupt pin 1, asynchronous |
| irq_req | output | 1 | Combined interrupt request to the CPU |

## Verification
Assertions check four things on every cycle:
- a synchronized falling edge on pin 0 always lands in the pending state, and an acknowledge without a new edge always empties it;
- a locked option bit never moves;
- an enabled pin-1 trigger always sets the flag, and a disabled source never sets it;
- the mask always blocks the request.

The bench scenarios cover what needs whole sequences:
- the four pin-1 trigger modes, including edges of the wrong polarity;
- re-assertion in level mode after a clear;
- the difference between edge-only and edge-plus-level on pin 0 after an acknowledge;
- the option write being ignored the second time.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic {
        OPT_OPEN,
        OPT_LOCKED
    } opt_state_e;

    typedef enum logic {
        P0_IDLE,
        P0_PENDING
    } p0_state_e;

    typedef enum logic {
        F1_CLEAR,
        F1_SET
    } f1_state_e;

    // Pin-1 control/status register bit positions
    localparam int C1_FLAG = 5;
    localparam int C1_EN   = 4;
    localparam int C1_LVL  = 3;
    localparam int C1_POL  = 2;
    localparam int C1_CLR  = 1;
    localparam int C1_PIN  = 0;

    // Option register bit position
    localparam int OPT_EDGE_ONLY = 1;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = prev_q & ~level;

endmodule

// File: rtl/irq0_channel.sv
module irq0_channel
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic opt_wr,
    input  logic opt_wbit,
    input  logic ack,
    input  logic level,
    input  logic fall,
    output logic edge_only,
    output logic req
);
    opt_state_e opt_state_q, opt_state_d;
    p0_state_e  p0_state_q, p0_state_d;
    logic       edge_only_q, edge_only_d;

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_state_q <= OPT_OPEN;
            edge_only_q <= 1'b0;
            p0_state_q  <= P0_IDLE;
        end else begin
            opt_state_q <= opt_state_d;
            edge_only_q <= edge_only_d;
            p0_state_q  <= p0_state_d;
        end
    end

    // Option write-once machine
    always_comb begin
        opt_state_d = opt_state_q;
        edge_only_d = edge_only_q;
        unique case (opt_state_q)
            OPT_OPEN: begin
                if (opt_wr) begin
                    edge_only_d = opt_wbit;
                    opt_state_d = OPT_LOCKED;
                end
            end
            OPT_LOCKED: begin
                opt_state_d = OPT_LOCKED;
            end
        endcase
    end

    // Pin-0 latch machine; a new edge wins over acknowledge
    always_comb begin
        p0_state_d = p0_state_q;
        unique case (p0_state_q)
            P0_IDLE:    if (fall)         p0_state_d = P0_PENDING;
            P0_PENDING: if (ack && !fall) p0_state_d = P0_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        edge_only = edge_only_q;
        req       = (p0_state_q == P0_PENDING) | (~edge_only_q & ~level);
    end

    assert_fall_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (p0_state_q == P0_PENDING));

    assert_ack_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fall) |=> (p0_state_q == P0_IDLE));

    assert_opt_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_state_q == OPT_LOCKED) |=> $stable(edge_only_q));

endmodule

// File: rtl/irq1_channel.sv
module irq1_channel
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_en,
    input  logic       wr_lvl,
    input  logic       wr_pol,
    input  logic       wr_clr,
    input  logic       level,
    input  logic       rise,
    input  logic       fall,
    output logic [7:0] ctrl_rdata,
    output logic       req
);
    f1_state_e f1_state_q, f1_state_d;
    logic      en_q, lvl_q, pol_q;
    logic      edge_hit, level_hit, trig, clr_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            lvl_q <= 1'b0;
            pol_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= wr_en;
            lvl_q <= wr_lvl;
            pol_q <= wr_pol;
        end
    end

    always_comb begin
        edge_hit  = pol_q ? rise : fall;
        level_hit = lvl_q & (pol_q ? level : ~level);
        trig      = en_q & (edge_hit | level_hit);
        clr_now   = ctrl_wr & wr_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f1_state_q <= F1_CLEAR;
        else        f1_state_q <= f1_state_d;
    end

    // Flag machine; a trigger wins over the clear strobe
    always_comb begin
        f1_state_d = f1_state_q;
        unique case (f1_state_q)
            F1_CLEAR: if (trig)             f1_state_d = F1_SET;
            F1_SET:   if (clr_now && !trig) f1_state_d = F1_CLEAR;
        endcase
    end

    always_comb begin
        ctrl_rdata          = 8'h00;
        ctrl_rdata[C1_FLAG] = (f1_state_q == F1_SET);
        ctrl_rdata[C1_EN]   = en_q;
        ctrl_rdata[C1_LVL]  = lvl_q;
        ctrl_rdata[C1_POL]  = pol_q;
        ctrl_rdata[C1_PIN]  = level;
        req                 = (f1_state_q == F1_SET) & en_q;
    end

    assert_trig_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (f1_state_q == F1_SET));

    assert_strobe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && !trig) |=> (f1_state_q == F1_CLEAR));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && f1_state_q == F1_CLEAR) |=> (f1_state_q == F1_CLEAR));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && trig) |=> (f1_state_q == F1_SET));

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int              ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 4'h3,
    parameter logic [ADDR_W-1:0] OPT_ADDR   = 4'h7,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              cpu_imask,
    input  logic              irq_ack,
    input  logic              pin0_n,
    input  logic              pin1,
    output logic              irq_req
);
    logic lvl0, rise0, fall0;
    logic lvl1, rise1, fall1;
    logic opt_wr, ctrl_wr;
    logic edge_only, req0, req1;
    logic [7:0] ctrl_rdata;

    assign opt_wr  = bus_we & (bus_addr == OPT_ADDR);
    assign ctrl_wr = bus_we & (bus_addr == CTRL1_ADDR);

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync0 (
        .clk(clk), .rst_n(rst_n), .pin_async(pin0_n),
        .level(lvl0), .rise(rise0), .fall(fall0)
    );

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync1 (
        .clk(clk), .rst_n(rst_n), .pin_async(pin1),
        .level(lvl1), .rise(rise1), .fall(fall1)
    );

    irq0_channel u_ch0 (
        .clk(clk), .rst_n(rst_n),
        .opt_wr(opt_wr), .opt_wbit(bus_wdata[OPT_EDGE_ONLY]),
        .ack(irq_ack), .level(lvl0), .fall(fall0),
        .edge_only(edge_only), .req(req0)
    );

    irq1_channel u_ch1 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_en(bus_wdata[C1_EN]), .wr_lvl(bus_wdata[C1_LVL]),
        .wr_pol(bus_wdata[C1_POL]), .wr_clr(bus_wdata[C1_CLR]),
        .level(lvl1), .rise(rise1), .fall(fall1),
        .ctrl_rdata(ctrl_rdata), .req(req1)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == CTRL1_ADDR)
            bus_rdata = ctrl_rdata;
        else if (bus_addr == OPT_ADDR)
            bus_rdata[OPT_EDGE_ONLY] = edge_only;
    end

    assign irq_req = ~cpu_imask & (req0 | req1);

    // rise0 is unused by design: pin 0 only triggers low
    logic unused_ok;
    assign unused_ok = rise0;

    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_imask |-> !irq_req);

endmodule

// File: tb/test_ext_irq_unit.sv
module test_ext_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       cpu_imask = 1'b0;
    logic       irq_ack = 1'b0;
    logic       pin0_n = 1'b1;
    logic       pin1 = 1'b0;
    logic       irq_req;

    localparam logic [3:0] A_CTRL = 4'h3;
    localparam logic [3:0] A_OPT  = 4'h7;

    int total = 0;
    int fails = 0;

    ext_irq_unit i_ext_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cpu_imask(cpu_imask),
        .irq_ack(irq_ack), .pin0_n(pin0_n), .pin1(pin1), .irq_req(irq_req)
    );

    always #4 clk = ~clk;

    // {pol, lvl, pin_start, pin_end, flag_after_enable, flag_after_change}
    localparam logic [5:0] VEC [8] = '{
        6'b00_10_01, // falling edge: fires
        6'b00_01_00, // falling mode, rising edge: ignored
        6'b01_10_01, // falling+low: edge fires
        6'b01_00_11, // falling+low: held low fires at once
        6'b10_01_01, // rising edge: fires
        6'b10_10_00, // rising mode, falling edge: ignored
        6'b11_01_01, // rising+high: edge fires
        6'b11_11_11  // rising+high: held high fires at once
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] r;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R1 reset state
        rd(A_CTRL, r); check("R1 ctrl", r, 8'h00);
        rd(A_OPT, r);  check("R1 opt", r, 8'h00);
        check("R1 irq_req", {7'd0, irq_req}, 8'h00);

        // R10 live pin readback
        pin1 = 1'b1; cycles(3);
        rd(A_CTRL, r); check("R10 pin high", {7'd0, r[0]}, 8'h01);
        pin1 = 1'b0; cycles(3);
        rd(A_CTRL, r); check("R10 pin low", {7'd0, r[0]}, 8'h00);

        // R6 disabled: falling and rising edges leave flag clear
        pin1 = 1'b1; cycles(4);
        pin1 = 1'b0; cycles(4);
        rd(A_CTRL, r); check("R6 flag", {7'd0, r[5]}, 8'h00);
        check("R6 irq_req", {7'd0, irq_req}, 8'h00);

        // R7 / R8 trigger table
        for (int i = 0; i < 8; i++) begin
            logic [7:0] mode;
            wr(A_CTRL, 8'h02);
            pin1 = VEC[i][3]; cycles(4);
            mode = {3'b000, 1'b1, VEC[i][4], VEC[i][5], 1'b1, 1'b0};
            wr(A_CTRL, mode);
            cycles(2);
            rd(A_CTRL, r); check($sformatf("R8 settle vec%0d", i), {7'd0, r[5]}, {7'd0, VEC[i][1]});
            pin1 = VEC[i][2]; cycles(4);
            rd(A_CTRL, r); check($sformatf("R7 trigger vec%0d", i), {7'd0, r[5]}, {7'd0, VEC[i][0]});
        end

        // R8/R11 level mode: clear while high keeps flag (rising+high, pin high)
        wr(A_CTRL, 8'h1E); cycles(1);
        rd(A_CTRL, r); check("R11 set wins", {7'd0, r[5]}, 8'h01);

        // R9 clear in edge mode, strobe reads 0
        wr(A_CTRL, 8'h14); // rising edge, enabled
        pin1 = 1'b0; cycles(4);
        pin1 = 1'b1; cycles(4);
        rd(A_CTRL, r); check("R7 rising set", {7'd0, r[5]}, 8'h01);

        // R2 mask
        cpu_imask = 1'b1; #1;
        check("R2 masked", {7'd0, irq_req}, 8'h00);
        cpu_imask = 1'b0; #1;
        check("R2 unmasked", {7'd0, irq_req}, 8'h01);

        wr(A_CTRL, 8'h16); cycles(1);
        rd(A_CTRL, r); check("R9 flag cleared", {7'd0, r[5]}, 8'h00);
        check("R9 strobe reads 0", {7'd0, r[1]}, 8'h00);
        wr(A_CTRL, 8'h02);
        pin1 = 1'b0; cycles(4);

        // R4 pin 0 edge+level default
        pin0_n = 1'b0; cycles(4);
        check("R3 edge+level req", {7'd0, irq_req}, 8'h01);
        ack_pulse(); cycles(1);
        check("R4 level holds after ack", {7'd0, irq_req}, 8'h01);
        pin0_n = 1'b1; cycles(4);
        check("R12 released", {7'd0, irq_req}, 8'h00);

        // R5 write-once option
        wr(A_OPT, 8'h02);
        rd(A_OPT, r); check("R5 first write", r, 8'h02);
        wr(A_OPT, 8'h00);
        rd(A_OPT, r); check("R5 second write ignored", r, 8'h02);

        // R3 latched edge in edge-only mode
        pin0_n = 1'b0; cycles(4);
        pin0_n = 1'b1; cycles(4);
        check("R3 latched after release", {7'd0, irq_req}, 8'h01);
        ack_pulse(); cycles(1);
        check("R12 ack clears", {7'd0, irq_req}, 8'h00);

        // R4 edge-only: held low after ack gives no request
        pin0_n = 1'b0; cycles(4);
        check("R3 second edge", {7'd0, irq_req}, 8'h01);
        ack_pulse(); cycles(2);
        check("R4 edge-only no level", {7'd0, irq_req}, 8'h00);
        pin0_n = 1'b1; cycles(4);

        // R1 reset restores option and unlocks
        rst_n = 1'b0; cycles(2); rst_n = 1'b1; cycles(2);
        rd(A_OPT, r); check("R1 opt after reset", r, 8'h00);
        wr(A_OPT, 8'h02);
        rd(A_OPT, r); check("R5 writable after reset", r, 8'h02);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule